// File: doc/BRIEF.md
# Shared-Line SAR Converter Bank Reader

This block is a host-side sequencer for a bank of 18-bit successive-approximation converters. The converters share one convert strobe, one serial clock and one serial data line, and each has its own active-low select. When a start request arrives, the block raises the shared convert strobe while every select is high. This starts a conversion in all devices at once and puts them in select-driven readout mode. The block then keeps every select high for the full worst-case conversion time, which prevents any device from producing a busy indication.

Once that window has passed, the devices are read one at a time in ascending index order. Lowering a select puts that device's most significant bit on the data line. The block generates the serial clock and shifts in the word from the most significant bit to the least. It then raises the select, so the data line is released before the next device is addressed. Each word is offered on a valid/ready port together with its device index. While an offered word is not yet accepted, the bus stays quiet. After the last device is read, the convert strobe drops, and the next cycle is held off for a set acquisition time.

Top module: `sbr_bank_reader`

## Requirements
- R1: During and after reset, with no start request, the convert strobe is low, every select is high, the serial clock is low, the result valid is low and busy is low.
- R2: A start request while idle raises the convert strobe while every select is high. No select goes low and the serial clock does not toggle until CONV_CYC cycles after that rise.
- R3: Devices are read in ascending index order 0 to N_DEV-1, once per conversion, and at most one select is low at any time.
- R4: While a select is low, the serial clock shows exactly 17 falling edges. The clock is low when the select falls and when it rises again.
- R5: Each delivered word equals the 18 bits the selected device presented, most significant bit first. Bit 17 of the result is the first bit on the line.
- R6: A result is offered with its device index on res_idx_o. While res_valid_o is high and res_ready_i is low, the word and the index stay unchanged.
- R7: While a result is pending, every select stays high and the serial clock stays low. No serial clock edge ever occurs while all selects are high.
- R8: Between one select rising and the next select falling there are at least 2*HALF_CYC cycles.
- R9: The convert strobe stays high from its rise until all N_DEV results of that conversion have been accepted. While it is low, every select is high.
- R10: After the convert strobe falls, it does not rise again for at least ACQ_CYC cycles, whatever the start input does.
- R11: Each high phase and each low phase of the serial clock lasts HALF_CYC cycles. The data line is sampled at the end of each low phase: once before the first falling edge, and once after each later falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion and readout cycle |
| busy_o | output | 1 | High from cycle start until the acquisition wait ends |
| cnv_o | output | 1 | Shared convert strobe |
| sclk_o | output | 1 | Shared serial clock |
| sel_n_o | output | N_DEV | Active-low select, one per converter |
| sdo_i | input | 1 | Shared serial data line |
| res_valid_o | output | 1 | Result word available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 18 | Result word, MSB in bit 17 |
| res_idx_o | output | IDX_W | Index of the device that produced the word |

## Verification
Two events can land on the same cycle: the end of a word capture with its hand-off to the consumer, and the inter-device gap that should lead to the next select. Back-pressure that stretches a pending result across the point where the gap would expire must hold off the next select. The bench provokes this by driving ready always high, then at random, then with long stalls. It judges the outcome by checking that no select falls and no clock edge appears while a word is pending, and that the pending word does not change. A second overlap is a held start request meeting the acquisition wait. The bench keeps start high throughout and measures the low time of the strobe.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int WORD_W = 18;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_READ,
        SQ_HOLD,
        SQ_GAP,
        SQ_ACQ
    } seq_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_LOW,
        RX_HIGH
    } rx_phase_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic sclk;
    } rx_stat_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sbr_timer.sv
module sbr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R2
    tmr_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sbr_word_rx.sv
module sbr_word_rx
    import sbr_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic              sdo_i,
    output rx_stat_t          stat_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int HC_W  = $clog2(HALF_CYC + 1);
    localparam int BIT_W = $clog2(WORD_W + 1);

    rx_phase_e         ph_q;
    logic [HC_W-1:0]   hc_q;
    logic [BIT_W-1:0]  nbit_q;
    logic [WORD_W-1:0] sh_q;
    logic              sclk_q;
    logic              done_q;
    logic              last_bit;

    assign last_bit = (nbit_q == BIT_W'(WORD_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= RX_IDLE;
            hc_q   <= '0;
            nbit_q <= '0;
            sh_q   <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                RX_IDLE: begin
                    if (go_i) begin
                        ph_q   <= RX_LOW;
                        hc_q   <= HC_W'(HALF_CYC - 1);
                        nbit_q <= '0;
                        sclk_q <= 1'b0;
                    end
                end
                RX_LOW: begin
                    if (hc_q == '0) begin
                        sh_q   <= {sh_q[WORD_W-2:0], sdo_i};
                        nbit_q <= nbit_q + 1'b1;
                        if (last_bit) begin
                            ph_q   <= RX_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            ph_q   <= RX_HIGH;
                            sclk_q <= 1'b1;
                            hc_q   <= HC_W'(HALF_CYC - 1);
                        end
                    end else begin
                        hc_q <= hc_q - 1'b1;
                    end
                end
                RX_HIGH: begin
                    if (hc_q == '0) begin
                        ph_q   <= RX_LOW;
                        sclk_q <= 1'b0;
                        hc_q   <= HC_W'(HALF_CYC - 1);
                    end else begin
                        hc_q <= hc_q - 1'b1;
                    end
                end
                default: ph_q <= RX_IDLE;
            endcase
        end
    end

    assign stat_o.busy = (ph_q != RX_IDLE);
    assign stat_o.done = done_q;
    assign stat_o.sclk = sclk_q;
    assign word_o      = sh_q;

    // R4
    rx_clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == RX_IDLE) |-> !sclk_q);
    // R4
    rx_end_low_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !sclk_q);
endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer
    import sbr_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int CONV_CYC = 64,
    parameter int ACQ_CYC  = 32,
    parameter int GAP_CYC  = 4,
    parameter int IDX_W    = 2,
    parameter int TMR_W    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rx_done_i,
    input  logic             res_ready_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    output logic             rx_go_o,
    output logic             busy_o,
    output logic             cnv_o,
    output logic [N_DEV-1:0] sel_n_o,
    output logic             res_valid_o,
    output logic [IDX_W-1:0] idx_o
);
    seq_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] go_idx;
    logic             cnv_q;
    logic             vld_q;
    logic             last_dev;
    logic [N_DEV-1:0] sel_q;

    assign last_dev = (idx_q == IDX_W'(N_DEV - 1));
    assign go_idx   = (st_q == SQ_CONV) ? '0 : idx_q + 1'b1;

    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        rx_go_o    = 1'b0;
        unique case (st_q)
            SQ_IDLE: if (start_i) begin
                st_d       = SQ_CONV;
                tmr_load_o = 1'b1;
                tmr_val_o  = TMR_W'(CONV_CYC - 1);
            end
            SQ_CONV: if (tmr_zero_i) begin
                st_d    = SQ_READ;
                rx_go_o = 1'b1;
            end
            SQ_READ: if (rx_done_i) st_d = SQ_HOLD;
            SQ_HOLD: if (res_ready_i) begin
                st_d       = SQ_GAP;
                tmr_load_o = 1'b1;
                tmr_val_o  = TMR_W'(GAP_CYC - 1);
            end
            SQ_GAP: if (tmr_zero_i) begin
                if (last_dev) begin
                    st_d       = SQ_ACQ;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TMR_W'(ACQ_CYC - 1);
                end else begin
                    st_d    = SQ_READ;
                    rx_go_o = 1'b1;
                end
            end
            SQ_ACQ: if (tmr_zero_i) st_d = SQ_IDLE;
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            cnv_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && st_d == SQ_CONV)
                cnv_q <= 1'b1;
            else if (st_q == SQ_GAP && st_d == SQ_ACQ)
                cnv_q <= 1'b0;
            if (rx_go_o)
                idx_q <= go_idx;
            if (st_q == SQ_READ && rx_done_i)
                vld_q <= 1'b1;
            else if (st_q == SQ_HOLD && res_ready_i)
                vld_q <= 1'b0;
        end
    end

    for (genvar d = 0; d < N_DEV; d++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[d] <= 1'b1;
            else if (rx_go_o)
                sel_q[d] <= (go_idx != IDX_W'(d));
            else if (rx_done_i)
                sel_q[d] <= 1'b1;
        end
    end

    assign busy_o      = (st_q != SQ_IDLE);
    assign cnv_o       = cnv_q;
    assign sel_n_o     = sel_q;
    assign res_valid_o = vld_q;
    assign idx_o       = idx_q;

    // R3
    one_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_q));
    // R9
    cnv_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cnv_q |-> (&sel_q));
    // R10
    acq_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ACQ) |=> !cnv_q);
endmodule

// File: rtl/sbr_bank_reader.sv
module sbr_bank_reader
    import sbr_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int HALF_CYC = 2,
    parameter int CONV_CYC = 67,
    parameter int ACQ_CYC  = 40,
    parameter int IDX_W    = idx_width(N_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              cnv_o,
    output logic              sclk_o,
    output logic [N_DEV-1:0]  sel_n_o,
    input  logic              sdo_i,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic [WORD_W-1:0] res_data_o,
    output logic [IDX_W-1:0]  res_idx_o
);
    localparam int GAP_CYC = 2 * HALF_CYC;
    localparam int TMR_MAX = imax(imax(CONV_CYC, ACQ_CYC), GAP_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             rx_go;
    rx_stat_t         rx_st;

    sbr_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    sbr_word_rx #(.HALF_CYC(HALF_CYC)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .go_i   (rx_go),
        .sdo_i  (sdo_i),
        .stat_o (rx_st),
        .word_o (res_data_o)
    );

    sbr_sequencer #(
        .N_DEV    (N_DEV),
        .CONV_CYC (CONV_CYC),
        .ACQ_CYC  (ACQ_CYC),
        .GAP_CYC  (GAP_CYC),
        .IDX_W    (IDX_W),
        .TMR_W    (TMR_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rx_done_i   (rx_st.done),
        .res_ready_i (res_ready_i),
        .tmr_zero_i  (tmr_zero),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .rx_go_o     (rx_go),
        .busy_o      (busy_o),
        .cnv_o       (cnv_o),
        .sel_n_o     (sel_n_o),
        .res_valid_o (res_valid_o),
        .idx_o       (res_idx_o)
    );

    assign sclk_o = rx_st.sclk;

    // R2
    cnv_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv_o) |-> (&sel_n_o));
    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !res_ready_i) |=>
            (res_valid_o && $stable(res_data_o) && $stable(res_idx_o)));
    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ((&sel_n_o) && !sclk_o));
    // R7
    bus_idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (&sel_n_o) |-> !sclk_o);
endmodule

// File: tb/sbr_bank_reader_tb.sv
module sbr_bank_reader_tb;
    import sbr_pkg::*;

    localparam int N     = 3;
    localparam int HALF  = 2;
    localparam int CONV  = 40;
    localparam int ACQ   = 12;
    localparam int IW    = idx_width(N);
    localparam int NCONV = 18;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              busy;
    logic              cnv;
    logic              sclk;
    logic [N-1:0]      sel_n;
    logic              sdo;
    logic              valid;
    logic              ready;
    logic [WORD_W-1:0] data;
    logic [IW-1:0]     idx;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sbr_bank_reader #(
        .N_DEV(N), .HALF_CYC(HALF), .CONV_CYC(CONV), .ACQ_CYC(ACQ)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy),
        .cnv_o(cnv), .sclk_o(sclk), .sel_n_o(sel_n), .sdo_i(sdo),
        .res_valid_o(valid), .res_ready_i(ready),
        .res_data_o(data), .res_idx_o(idx)
    );

    function automatic logic [WORD_W-1:0] exp_word(input int k, input int d);
        if (k == 0) return '0;
        if (k == 1) return '1;
        if (k == 2) return (d % 2 == 0) ? 18'h2AAAA : 18'h15555;
        if (k == 3) return 18'h20000 >> d;
        return WORD_W'((k * 32'h2D1B + d * 32'h1357 + 32'h0A5C3) ^ (k << 9));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, cyc);
        end
    endtask

    // converter model: one shared shifter, loaded when a select falls
    int conv_k = 0;
    int act_dev = -1;
    logic [WORD_W-1:0] dev_sh = '0;
    always @(posedge cnv) conv_k++;
    always @(sel_n) begin
        int cur;
        cur = -1;
        for (int d = 0; d < N; d++) if (!sel_n[d]) cur = d;
        if (cur >= 0 && cur != act_dev) dev_sh = exp_word(conv_k - 1, cur);
        act_dev = cur;
    end
    always @(negedge sclk) if (act_dev >= 0) dev_sh = dev_sh << 1;
    assign sdo = (act_dev >= 0) ? dev_sh[WORD_W-1] : 1'bz;

    // ready patterns: always, random, long stalls
    int conv_done = 0;
    always @(posedge clk) begin
        #2;
        if (conv_done < 6)       ready = 1'b1;
        else if (conv_done < 12) ready = 1'($urandom % 2);
        else                     ready = ((cyc % 37) == 0);
    end

    // monitor, sampled mid-period
    logic p_cnv = 0, p_sclk = 0, p_valid = 0, p_ready = 0;
    logic [N-1:0] p_sel = '1;
    logic [WORD_W-1:0] p_data = '0;
    logic [IW-1:0] p_idx = '0;
    int t_rise = 0, t_fall = 0, t_selr = 0, t_edge = 0;
    int seen_fall = 0, n_res = 0, exp_dev = 0, falls = 0, on_bus = 0, total = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cnv && !p_cnv) begin
                chk(&sel_n, "R2 selects high at strobe rise", sel_n, '1);
                if (seen_fall) chk(cyc - t_fall >= ACQ, "R10 acquisition wait", cyc - t_fall, ACQ);
                t_rise = cyc; exp_dev = 0; n_res = 0;
            end
            if (!cnv && p_cnv) begin
                chk(n_res == N, "R9 strobe held over all reads", n_res, N);
                t_fall = cyc; seen_fall = 1; conv_done++;
            end
            if (!cnv) chk(&sel_n, "R9 selects high while strobe low", sel_n, '1);
            if (sel_n != p_sel) begin
                chk($countones(~sel_n) <= 1, "R3 single select", ~sel_n, 0);
                for (int d = 0; d < N; d++) begin
                    if (!sel_n[d] && p_sel[d]) begin
                        chk(d == exp_dev, "R3 read order", d, exp_dev);
                        chk(cyc - t_rise >= CONV, "R2 conversion window", cyc - t_rise, CONV);
                        chk(cnv, "R9 strobe high during read", cnv, 1);
                        chk(!sclk, "R4 clock low at select fall", sclk, 0);
                        chk(!valid, "R7 no select while pending", valid, 0);
                        if (d > 0) chk(cyc - t_selr >= 2 * HALF, "R8 inter-device gap", cyc - t_selr, 2 * HALF);
                        falls = 0; t_edge = cyc; on_bus = 1;
                    end
                    if (sel_n[d] && !p_sel[d]) begin
                        chk(falls == WORD_W - 1, "R4 falling edges per word", falls, WORD_W - 1);
                        chk(!sclk, "R4 clock low at select rise", sclk, 0);
                        t_selr = cyc; on_bus = 0; exp_dev++;
                    end
                end
            end
            if (sclk != p_sclk) begin
                if (on_bus) begin
                    chk(cyc - t_edge == HALF, "R11 half period", cyc - t_edge, HALF);
                    t_edge = cyc;
                    if (!sclk) falls++;
                end else begin
                    chk(0, "R7 clock edge with bus idle", sclk, p_sclk);
                end
            end
            if (valid && p_valid && !p_ready) begin
                chk(data == p_data, "R6 data held under stall", data, p_data);
                chk(idx == p_idx, "R6 index held under stall", idx, p_idx);
            end
            if (valid) chk((&sel_n) && !sclk, "R7 bus quiet while pending", {sclk, sel_n}, {1'b0, {N{1'b1}}});
            if (valid && ready) begin
                chk(int'(idx) == n_res, "R6 result index", idx, n_res);
                chk(data == exp_word(conv_k - 1, n_res), "R5 result word", data, exp_word(conv_k - 1, n_res));
                n_res++; total++;
            end
        end
        p_cnv = cnv; p_sclk = sclk; p_valid = valid; p_ready = ready;
        p_sel = sel_n; p_data = data; p_idx = idx;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!cnv && (&sel_n) && !sclk && !valid && !busy, "R1 reset state",
            {cnv, sclk, valid, busy}, 0);
        rst = 1'b0;
        repeat (25) @(negedge clk);
        chk(!cnv && (&sel_n) && !busy, "R1 idle without start", {cnv, busy}, 0);
        start = 1'b1;
        while (conv_done < NCONV) @(negedge clk);
        start = 1'b0;
        repeat (ACQ + 20) @(negedge clk);
        chk(!cnv && !busy, "R1 idle after start removed", {cnv, busy}, 0);
        chk(total == NCONV * N, "R5 total results", total, NCONV * N);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d conversions", conv_done, NCONV);
            summary();
            $finish;
        end
    end
endmodule